// File: doc/BRIEF.md
# Flagged Bidirectional Register Port with Parity

This block joins two 8-bit sides, A and B, through two independent holding registers. The forward register takes a byte from side A and presents it on side B together with a generated parity bit. The return register takes a byte and a parity bit from side B and presents the byte on side A, together with an active-low parity-error indication. Each register has its own load strobe, its own active-low load enable and its own active-low output enable.

Each register carries a ready flag. The flag goes high when the register loads. The consumer reads the register by pulling the output enable low, and acknowledges the read by returning the enable high. That rising edge clears the flag. The block runs on one system clock. Both strobes and both enables are sampled on that clock, and edges are found by comparing each input with its value in the previous cycle. The pads are modelled as a value output paired with a drive-enable output.

Top module: `flag_reg_port`

## Requirements
- R1: When the sampled `fwd_strobe` is high after being low in the previous cycle and `fwd_load_n` is low, the forward register captures `a_in` on that clock edge. Under the same condition on `ret_strobe`/`ret_load_n`, the return register captures `b_in` and `par_in`.
- R2: A register keeps its contents if its load enable is high at the strobe edge, and also while its strobe stays high over several cycles. Only the first cycle of a strobe pulse can load.
- R3: A register's flag is high from the clock edge that loads it.
- R4: A flag clears on the clock edge where that path's output enable is seen high after being low. With no load and no such edge, the flag keeps its value.
- R5: If a load and a flag-clearing enable edge fall in the same cycle on one path, the flag ends high.
- R6: `b_drive` equals the inverse of `fwd_oe_n`, and `a_drive` equals the inverse of `ret_oe_n`. `b_out` shows the forward register and `a_out` shows the return data register.
- R7: `par_out` is 1 when the forward register holds an even number of ones (zero ones counts as even) and 0 otherwise. `par_drive` always equals `b_drive`.
- R8: `err_n` is 1 while `ret_oe_n` is high. While `ret_oe_n` is low, `err_n` is 1 when the return data plus the stored parity bit hold an odd number of ones, and 0 when they hold an even number.
- R9: A clock edge with `rst_n` low clears both data registers, the stored parity bit and both flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| a_in | input | 8 | Data arriving on side A |
| b_in | input | 8 | Data arriving on side B |
| par_in | input | 1 | Parity bit arriving with `b_in` |
| fwd_strobe | input | 1 | Load strobe of the forward register, acts on its rising edge |
| fwd_load_n | input | 1 | Forward load enable, active low |
| fwd_oe_n | input | 1 | Forward output enable, active low; its rising edge clears the forward flag |
| ret_strobe | input | 1 | Load strobe of the return register, acts on its rising edge |
| ret_load_n | input | 1 | Return load enable, active low |
| ret_oe_n | input | 1 | Return output enable, active low; its rising edge clears the return flag |
| b_out | output | 8 | Forward register value for side B |
| b_drive | output | 1 | Side B drive enable |
| par_out | output | 1 | Generated parity value |
| par_drive | output | 1 | Parity pin drive enable |
| a_out | output | 8 | Return register value for side A |
| a_drive | output | 1 | Side A drive enable |
| fwd_flag | output | 1 | Forward register ready flag |
| ret_flag | output | 1 | Return register ready flag |
| err_n | output | 1 | Parity error, active low |

## Verification
The assertions assume that every strobe and enable is a level the system clock samples cleanly. They also assume that data and load enables are valid at the clock edge where a strobe is first seen high. The bench changes every input only on the falling clock edge, holds each strobe high for at least one full cycle, and checks registered results one full cycle later. Overlaps are created on purpose only in the cases that test them: a strobe held high over several edges, and a load that coincides with an enable release.

// File: rtl/flag_port_pkg.sv
// Package flag_port_pkg
// Purpose : shared width parameter and a parity helper for the flagged
//           register port.
// Assumes : nothing beyond the default byte-wide port.
package flag_port_pkg;
    parameter int unsigned PORT_W = 8;

    // Returns 1 when the vector has an even number of ones.
    function automatic logic even_ones(input logic [PORT_W-1:0] v);
        return ~(^v);
    endfunction
endpackage

// File: rtl/rise_detect.sv
// Module rise_detect
// Purpose : reports the first sampled cycle in which a level is high after
//           being low in the cycle before.
// Assumes : the input is already synchronous to clk; IDLE sets the value the
//           history register takes in reset, so that an input at rest makes
//           no false edge.
module rise_detect #(
    parameter logic IDLE = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic rise
);
    logic level_q;

    // Keep the previous sample of the level.
    always_ff @(posedge clk) begin
        if (!rst_n) level_q <= IDLE;
        else        level_q <= level;
    end

    // Edge = high now and low in the previous cycle.
    assign rise = level & ~level_q;
endmodule

// File: rtl/flag_path.sv
// Module flag_path
// Purpose : one holding register with its ready flag. It loads on a strobe
//           edge while the load enable is low. The flag sets on a load and
//           clears on the rising edge of the output enable; a load wins.
// Assumes : strobe, load_n and oe_n are synchronous to clk.
module flag_path #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         strobe,
    input  logic         load_n,
    input  logic         oe_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q,
    output logic         flag
);
    logic strobe_rise;
    logic oe_rise;
    logic load_now;

    rise_detect #(.IDLE(1'b0)) strobe_edge_i (
        .clk(clk), .rst_n(rst_n), .level(strobe), .rise(strobe_rise)
    );
    rise_detect #(.IDLE(1'b1)) oe_edge_i (
        .clk(clk), .rst_n(rst_n), .level(oe_n), .rise(oe_rise)
    );

    assign load_now = strobe_rise & ~load_n;

    // Hold the data word; capture it only on a qualified strobe edge.
    always_ff @(posedge clk) begin
        if (!rst_n)        q <= '0;
        else if (load_now) q <= d;
    end

    // Ready flag: a load sets it, the enable release clears it, set wins.
    always_ff @(posedge clk) begin
        if (!rst_n)        flag <= 1'b0;
        else if (load_now) flag <= 1'b1;
        else if (oe_rise)  flag <= 1'b0;
    end

    // R1: a qualified strobe edge captures the input word.
    assert_load_capture_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && !$past(strobe) && !load_n) |=> (q == $past(d)));

    // R2: without a qualified strobe edge the contents stay.
    assert_hold_contents_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(strobe && !$past(strobe) && !load_n) |=> $stable(q));

    // R3 and R5: a load leaves the flag high, even with an enable release.
    assert_flag_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && !$past(strobe) && !load_n) |=> flag);

    // R4: an enable release without a load clears the flag.
    assert_flag_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_n && !$past(oe_n) && !(strobe && !$past(strobe) && !load_n)) |=> !flag);
endmodule

// File: rtl/flag_reg_port.sv
// Module flag_reg_port
// Purpose : bidirectional byte port with two flagged holding registers. The
//           forward path takes side A, drives side B and generates parity.
//           The return path takes side B with a parity bit, drives side A and
//           reports a parity error.
// Assumes : one clock domain; pads are modelled as value plus drive enable.
module flag_reg_port
    import flag_port_pkg::*;
#(
    parameter int unsigned W = PORT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    input  logic         par_in,
    input  logic         fwd_strobe,
    input  logic         fwd_load_n,
    input  logic         fwd_oe_n,
    input  logic         ret_strobe,
    input  logic         ret_load_n,
    input  logic         ret_oe_n,
    output logic [W-1:0] b_out,
    output logic         b_drive,
    output logic         par_out,
    output logic         par_drive,
    output logic [W-1:0] a_out,
    output logic         a_drive,
    output logic         fwd_flag,
    output logic         ret_flag,
    output logic         err_n
);
    localparam int unsigned RW = W + 1;

    logic [W-1:0]  fwd_q;
    logic [RW-1:0] ret_q;

    flag_path #(.W(W)) fwd_path_i (
        .clk(clk), .rst_n(rst_n), .strobe(fwd_strobe), .load_n(fwd_load_n),
        .oe_n(fwd_oe_n), .d(a_in), .q(fwd_q), .flag(fwd_flag)
    );

    flag_path #(.W(RW)) ret_path_i (
        .clk(clk), .rst_n(rst_n), .strobe(ret_strobe), .load_n(ret_load_n),
        .oe_n(ret_oe_n), .d({par_in, b_in}), .q(ret_q), .flag(ret_flag)
    );

    // Forward pads: register value, generated parity, shared enable.
    always_comb begin
        b_out     = fwd_q;
        b_drive   = ~fwd_oe_n;
        par_out   = even_ones(fwd_q);
        par_drive = ~fwd_oe_n;
    end

    // Return pads: data value and an error flag, idle high when not enabled.
    always_comb begin
        a_out   = ret_q[W-1:0];
        a_drive = ~ret_oe_n;
        err_n   = ret_oe_n | (^ret_q);
    end

    // R7: the parity pin follows the side B drive enable.
    assert_par_follows_oe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        par_drive == b_drive);

    // R7: the parity bit cannot change while the forward register is unchanged.
    assert_par_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(b_out) |-> $stable(par_out));

    // R8: with the return output disabled the error output is inactive.
    assert_err_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ret_oe_n |-> err_n);
endmodule

// File: tb/flag_reg_port_tb_top.sv
module flag_reg_port_tb_top;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] a_in, b_in;
    logic       par_in;
    logic       fwd_strobe, fwd_load_n, fwd_oe_n;
    logic       ret_strobe, ret_load_n, ret_oe_n;
    logic [7:0] b_out, a_out;
    logic       b_drive, par_out, par_drive, a_drive, fwd_flag, ret_flag, err_n;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    flag_reg_port dut_i (
        .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in), .par_in(par_in),
        .fwd_strobe(fwd_strobe), .fwd_load_n(fwd_load_n), .fwd_oe_n(fwd_oe_n),
        .ret_strobe(ret_strobe), .ret_load_n(ret_load_n), .ret_oe_n(ret_oe_n),
        .b_out(b_out), .b_drive(b_drive), .par_out(par_out), .par_drive(par_drive),
        .a_out(a_out), .a_drive(a_drive), .fwd_flag(fwd_flag), .ret_flag(ret_flag),
        .err_n(err_n)
    );

    // Fields: a byte, b byte, parity in, expected par_out, expected err_n.
    localparam logic [18:0] VEC [6] = '{
        {8'h00, 8'h00, 1'b0, 1'b1, 1'b0},
        {8'hFF, 8'h01, 1'b0, 1'b1, 1'b1},
        {8'h01, 8'h01, 1'b1, 1'b0, 1'b0},
        {8'hA5, 8'h80, 1'b1, 1'b1, 1'b0},
        {8'h7F, 8'hFE, 1'b0, 1'b0, 1'b1},
        {8'h3C, 8'hFF, 1'b1, 1'b1, 1'b1}
    };

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; a_in = '0; b_in = '0; par_in = 1'b0;
        fwd_strobe = 1'b0; fwd_load_n = 1'b1; fwd_oe_n = 1'b1;
        ret_strobe = 1'b0; ret_load_n = 1'b1; ret_oe_n = 1'b1;
        @(negedge clk);
        tick(); tick();
        rst_n = 1'b1;
        tick();

        // Reset state R9, idle outputs R6 and R8.
        check("R9 fwd_flag after reset", fwd_flag, 0);
        check("R9 ret_flag after reset", ret_flag, 0);
        check("R6 b_drive idle", b_drive, 0);
        check("R6 a_drive idle", a_drive, 0);
        check("R8 err_n idle", err_n, 1);

        // Vector walk: load both paths, read, release.
        foreach (VEC[i]) begin
            a_in = VEC[i][18:11]; b_in = VEC[i][10:3]; par_in = VEC[i][2];
            fwd_strobe = 1'b1; fwd_load_n = 1'b0;
            ret_strobe = 1'b1; ret_load_n = 1'b0;
            tick();
            fwd_strobe = 1'b0; fwd_load_n = 1'b1;
            ret_strobe = 1'b0; ret_load_n = 1'b1;
            tick();
            check("R3 fwd_flag after load", fwd_flag, 1);
            check("R3 ret_flag after load", ret_flag, 1);
            fwd_oe_n = 1'b0; ret_oe_n = 1'b0;
            #1;
            check("R6 b_drive enabled", b_drive, 1);
            check("R1 b_out value", b_out, VEC[i][18:11]);
            check("R1 a_out value", a_out, VEC[i][10:3]);
            check("R7 par_drive enabled", par_drive, 1);
            check("R7 par_out value", par_out, VEC[i][1]);
            check("R8 err_n value", err_n, VEC[i][0]);
            tick();
            check("R4 fwd_flag holds while read", fwd_flag, 1);
            fwd_oe_n = 1'b1; ret_oe_n = 1'b1;
            tick();
            check("R4 fwd_flag cleared", fwd_flag, 0);
            check("R4 ret_flag cleared", ret_flag, 0);
            check("R6 a_drive released", a_drive, 0);
            check("R7 par_drive released", par_drive, 0);
            check("R8 err_n released", err_n, 1);
        end

        // R2: strobe with load enable high does nothing (registers hold 3C / FF).
        a_in = 8'h11; b_in = 8'h22; par_in = 1'b0;
        fwd_strobe = 1'b1; ret_strobe = 1'b1;
        tick();
        fwd_strobe = 1'b0; ret_strobe = 1'b0;
        tick();
        check("R2 fwd_flag without enable", fwd_flag, 0);
        check("R2 ret_flag without enable", ret_flag, 0);
        fwd_oe_n = 1'b0; ret_oe_n = 1'b0;
        #1;
        check("R2 b_out unchanged", b_out, 8'h3C);
        check("R2 a_out unchanged", a_out, 8'hFF);
        tick();
        fwd_oe_n = 1'b1; ret_oe_n = 1'b1;
        tick();

        // R2: a strobe held high loads only on its first cycle.
        a_in = 8'h5A; fwd_strobe = 1'b1; fwd_load_n = 1'b0;
        tick();
        a_in = 8'hC3;
        tick(); tick();
        fwd_strobe = 1'b0; fwd_load_n = 1'b1;
        tick();
        fwd_oe_n = 1'b0;
        #1;
        check("R2 held strobe keeps first byte", b_out, 8'h5A);
        check("R7 par_out for 5A", par_out, 1);
        tick();

        // R5: load and enable release in the same cycle leave the flag high.
        fwd_oe_n = 1'b1; fwd_strobe = 1'b1; fwd_load_n = 1'b0; a_in = 8'h07;
        tick();
        fwd_strobe = 1'b0; fwd_load_n = 1'b1;
        check("R5 flag set wins over clear", fwd_flag, 1);
        tick();
        check("R4 flag holds without edge", fwd_flag, 1);
        fwd_oe_n = 1'b0;
        #1;
        check("R5 byte loaded during release", b_out, 8'h07);
        check("R7 par_out for 07", par_out, 0);
        tick();
        fwd_oe_n = 1'b1;
        tick();
        check("R4 flag cleared after read", fwd_flag, 0);

        // R9: reset clears data, parity bit and flags.
        ret_strobe = 1'b1; ret_load_n = 1'b0; b_in = 8'h0F; par_in = 1'b1;
        tick();
        ret_strobe = 1'b0; ret_load_n = 1'b1;
        rst_n = 1'b0;
        tick();
        rst_n = 1'b1;
        fwd_oe_n = 1'b0; ret_oe_n = 1'b0;
        #1;
        check("R9 ret_flag cleared", ret_flag, 0);
        check("R9 b_out cleared", b_out, 8'h00);
        check("R9 a_out cleared", a_out, 8'h00);
        check("R9 par_out for zero", par_out, 1);
        check("R9 stored parity cleared", err_n, 0);
        tick();
        fwd_oe_n = 1'b1; ret_oe_n = 1'b1;
        tick();

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule